// File: doc/BRIEF.md
# CAN Bit-Timing Synchronizer

This block recovers bit timing for a CAN receiver from the serial receive line alone. An 8-bit prescaler counter, clocked by the fast system clock, sets the bit period through its terminal count. Three one-hot rate switches choose that terminal count: slow (125 kbit/s, 8 µs), medium (250 kbit/s, 4 µs) or fast (500 kbit/s, 2 µs). The defaults of 64, 32 and 16 system clocks per bit keep the same 4:2:1 ratio.

The receive line first passes through a two-flop synchronizer. After reset, the block waits until the bus has been recessive for eleven consecutive bit-spaced samples. Only then does it arm. The first recessive-to-dominant transition on the armed bus marks start of frame. That edge restarts the prescaler. From there the block emits two strobes every bit period: a bit-boundary strobe on the first clock of each bit, and a mid-bit sample strobe half a period later. It does this until a downstream frame decoder raises the frame-done input. The block does not resynchronise on later edges.

A rate selection that is not exactly one-hot is a configuration fault. It is reported at once and holds the block in its bus-idle search.

Top module: `can_bit_sync`

## Requirements
- R1: `rate_sel` bit 0 selects a bit period of P_SLOW clocks (default 64), bit 1 selects P_MID clocks (default 32), and bit 2 selects P_FAST clocks (default 16).
- R2: `cfg_err` is high in the same cycle whenever `rate_sel` has zero or more than one bit set (for example 000, 011 or 111). While it is high, `in_frame` stays low and the block returns to the bus-idle search.
- R3: After reset, after frame-done and after a configuration fault, the block arms only when 11 consecutive samples of the synchronized line, taken once per bit period, are recessive (1). A falling edge seen before that starts no frame.
- R4: On an armed bus, a 1-to-0 transition of `rx` that is present before clock edge k makes `in_frame` and `boundary_stb` high in the cycle that follows edge k+2.
- R5: Inside a frame, `boundary_stb` is high for exactly one clock every P clocks of the selected rate.
- R6: `sample_stb` is high for one clock exactly P/2 clocks after each `boundary_stb`. The two strobes are never high in the same cycle.
- R7: Transitions on `rx` during a frame do not move either strobe.
- R8: `frame_done` high during a frame makes `in_frame` low in the next cycle and stops both strobes. A new frame then needs the idle condition of R3 again.
- R9: A configuration fault in the same cycle as a start-of-frame edge wins: no frame starts and no strobe appears.
- R10: During and just after synchronous reset, `in_frame`, `boundary_stb` and `sample_stb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx | input | 1 | Asynchronous CAN receive line, 1 = recessive |
| rate_sel | input | 3 | One-hot rate switches: bit0 slow, bit1 medium, bit2 fast |
| frame_done | input | 1 | End-of-frame indication from the downstream decoder |
| in_frame | output | 1 | High while bit timing is locked to a frame |
| boundary_stb | output | 1 | One-clock strobe on the first clock of each bit |
| sample_stb | output | 1 | One-clock strobe at the middle of each bit |
| cfg_err | output | 1 | Rate switches are not exactly one-hot |

## Verification
Two functions can collide in the same cycle: arming a frame on a start-of-frame edge, and the forced return to idle on a bad rate selection. The bench drives the falling edge on an armed bus, counts the two synchronizer stages, and makes the rate switches non-one-hot for exactly the one cycle in which the edge is detected. It judges the outcome in three ways: `cfg_err` must be high in that cycle, no strobe may appear afterwards, and `in_frame` must stay low. A later frame must need a fresh eleven-bit idle period before it starts.

// File: rtl/can_bit_sync_pkg.sv
package can_bit_sync_pkg;

    // Controller states: searching for bus idle, armed for start of frame, locked to a frame.
    typedef enum logic [1:0] {
        ST_WAIT_IDLE = 2'd0,
        ST_ARMED     = 2'd1,
        ST_FRAME     = 2'd2
    } sync_state_e;

    // Decoded rate configuration carried from the switch decoder to the datapath.
    typedef struct packed {
        logic [7:0] tc;     // prescaler terminal count (period - 1)
        logic [7:0] half;   // offset of the mid-bit sample from the boundary
        logic       bad;    // switches not exactly one-hot
    } rate_cfg_t;

    function automatic logic [7:0] half_of(input logic [7:0] tc);
        logic [8:0] per;
        per = {1'b0, tc} + 9'd1;
        return per[8:1];
    endfunction

endpackage

// File: rtl/can_bit_sync_rate.sv
module can_bit_sync_rate
    import can_bit_sync_pkg::*;
#(
    parameter int P_SLOW = 64,
    parameter int P_MID  = 32,
    parameter int P_FAST = 16
) (
    input  logic [2:0] rate_sel,
    output rate_cfg_t  cfg
);
    localparam logic [7:0] TC_SLOW = 8'(P_SLOW - 1);
    localparam logic [7:0] TC_MID  = 8'(P_MID - 1);
    localparam logic [7:0] TC_FAST = 8'(P_FAST - 1);

    logic [7:0] tc_sel;

    always_comb begin
        unique case (rate_sel)
            3'b001:  tc_sel = TC_SLOW;
            3'b010:  tc_sel = TC_MID;
            3'b100:  tc_sel = TC_FAST;
            default: tc_sel = TC_SLOW;
        endcase
        cfg.tc   = tc_sel;
        cfg.half = half_of(tc_sel);
        cfg.bad  = ($countones(rate_sel) != 1);
    end

endmodule

// File: rtl/can_bit_sync_rx.sv
module can_bit_sync_rx #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx,
    output logic rx_s,
    output logic fall_edge
);
    logic [STAGES-1:0] chain;
    logic              rx_d;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b1;
                else     chain[0] <= rx;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b1;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rx_d <= 1'b1;
        else     rx_d <= chain[STAGES-1];
    end

    assign rx_s      = chain[STAGES-1];
    assign fall_edge = rx_d & ~rx_s;

endmodule

// File: rtl/can_bit_sync_presc.sv
module can_bit_sync_presc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         restart,
    input  logic [W-1:0] tc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || restart)  cnt <= '0;
        else if (!en)        cnt <= '0;
        else if (cnt >= tc)  cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    // R4: a hard sync always lands the counter on the first clock of a bit
    p_restart_zero_r4: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));

    // R5: the counter never runs past its terminal count while the rate holds
    p_no_overrun_r5: assert property (@(posedge clk) disable iff (rst)
        (en && !restart && cnt <= tc) |=> ($stable(tc) -> (cnt <= tc)));

endmodule

// File: rtl/can_bit_sync_ctrl.sv
module can_bit_sync_ctrl
    import can_bit_sync_pkg::*;
#(
    parameter int IDLE_BITS = 11
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_bad,
    input  logic        fall_edge,
    input  logic        rx_s,
    input  logic        at_half,
    input  logic        frame_done,
    output sync_state_e state,
    output logic        start,
    output logic        cnt_en
);
    localparam int OW = $clog2(IDLE_BITS + 1);
    localparam logic [OW-1:0] LAST_ONE = OW'(IDLE_BITS - 1);

    logic [OW-1:0] ones, ones_nxt;
    sync_state_e   nxt;

    always_comb begin
        nxt      = state;
        ones_nxt = ones;
        start    = 1'b0;
        if (cfg_bad) begin
            nxt      = ST_WAIT_IDLE;
            ones_nxt = '0;
        end else begin
            unique case (state)
                ST_WAIT_IDLE: begin
                    if (at_half) begin
                        if (!rx_s) begin
                            ones_nxt = '0;
                        end else if (ones == LAST_ONE) begin
                            nxt      = ST_ARMED;
                            ones_nxt = '0;
                        end else begin
                            ones_nxt = ones + 1'b1;
                        end
                    end
                end
                ST_ARMED: begin
                    if (fall_edge) begin
                        nxt   = ST_FRAME;
                        start = 1'b1;
                    end
                end
                ST_FRAME: begin
                    if (frame_done) begin
                        nxt      = ST_WAIT_IDLE;
                        ones_nxt = '0;
                    end
                end
                default: nxt = ST_WAIT_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_WAIT_IDLE;
            ones  <= '0;
        end else begin
            state <= nxt;
            ones  <= ones_nxt;
        end
    end

    assign cnt_en = (state != ST_ARMED) && !cfg_bad;

    // R2: a bad switch setting always sends the block back to the idle search
    p_cfg_forces_wait_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_bad |=> (state == ST_WAIT_IDLE));

    // R3: arming only happens on a recessive mid-bit sample
    p_arm_on_recessive_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && $past(state) == ST_WAIT_IDLE) |-> ($past(rx_s) && $past(at_half)));

    // R4: a frame is entered only from the armed state on a falling edge
    p_frame_from_armed_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FRAME && $past(state) != ST_FRAME) |->
            ($past(state) == ST_ARMED && $past(fall_edge)));

    // R8: frame-done leaves the frame in one cycle
    p_done_exits_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FRAME && frame_done) |=> (state == ST_WAIT_IDLE));

endmodule

// File: rtl/can_bit_sync.sv
module can_bit_sync
    import can_bit_sync_pkg::*;
#(
    parameter int P_SLOW      = 64,
    parameter int P_MID       = 32,
    parameter int P_FAST      = 16,
    parameter int IDLE_BITS   = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx,
    input  logic [2:0] rate_sel,
    input  logic       frame_done,
    output logic       in_frame,
    output logic       boundary_stb,
    output logic       sample_stb,
    output logic       cfg_err
);
    rate_cfg_t   cfg;
    sync_state_e state;
    logic        rx_s, fall_edge, start, cnt_en;
    logic [7:0]  cnt;

    can_bit_sync_rate #(.P_SLOW(P_SLOW), .P_MID(P_MID), .P_FAST(P_FAST)) u_rate (
        .rate_sel (rate_sel),
        .cfg      (cfg)
    );

    can_bit_sync_rx #(.STAGES(SYNC_STAGES)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .rx        (rx),
        .rx_s      (rx_s),
        .fall_edge (fall_edge)
    );

    can_bit_sync_ctrl #(.IDLE_BITS(IDLE_BITS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cfg_bad    (cfg.bad),
        .fall_edge  (fall_edge),
        .rx_s       (rx_s),
        .at_half    (cnt == cfg.half),
        .frame_done (frame_done),
        .state      (state),
        .start      (start),
        .cnt_en     (cnt_en)
    );

    can_bit_sync_presc #(.W(8)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .en      (cnt_en),
        .restart (start),
        .tc      (cfg.tc),
        .cnt     (cnt)
    );

    assign in_frame     = (state == ST_FRAME);
    assign boundary_stb = in_frame && (cnt == 8'd0);
    assign sample_stb   = in_frame && (cnt == cfg.half);
    assign cfg_err      = cfg.bad;

    // R6: boundary and sample strobes never coincide
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(boundary_stb && sample_stb));

    // R9: a configuration fault leaves no frame behind it
    p_cfg_no_frame_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> !in_frame);

    // R10: nothing leaves the block in the cycle after reset
    p_reset_quiet_r10: assert property (@(posedge clk)
        rst |=> (!in_frame && !boundary_stb && !sample_stb));

endmodule

// File: tb/can_bit_sync_tb_top.sv
module can_bit_sync_tb_top;
    localparam int PS = 64;
    localparam int PM = 32;
    localparam int PF = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx = 1'b1;
    logic [2:0] rate_sel = 3'b001;
    logic       frame_done = 1'b0;
    logic       in_frame, boundary_stb, sample_stb, cfg_err;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    string cur_req = "R10";
    bit    done_flag = 1'b0;

    typedef struct {
        int    cyc;
        bit    kind;   // 1 = boundary strobe, 0 = sample strobe
        string req;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    can_bit_sync #(.P_SLOW(PS), .P_MID(PM), .P_FAST(PF), .IDLE_BITS(11), .SYNC_STAGES(2)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .rx           (rx),
        .rate_sel     (rate_sel),
        .frame_done   (frame_done),
        .in_frame     (in_frame),
        .boundary_stb (boundary_stb),
        .sample_stb   (sample_stb),
        .cfg_err      (cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp_v);
        end
    endtask

    // Monitor: every strobe must match the head of the scoreboard queue.
    always @(negedge clk) begin
        if (!rst && !done_flag && (boundary_stb || sample_stb)) begin
            if (sb_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL %s unexpected strobe at cycle %0d: actual=%0d expected=none",
                         cur_req, cyc, boundary_stb ? 1 : 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.cyc == cyc, e.req, cyc, e.cyc);
                check(e.kind == boundary_stb, e.req, int'(boundary_stb), int'(e.kind));
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive a start-of-frame edge on an armed bus and push the expected strobes.
    task automatic run_frame(input int per, input int nb, input string req, input bit wiggle);
        int base;
        int endc;
        @(negedge clk);
        rx   = 1'b0;
        base = cyc + 3;               // two sync stages plus the state register
        endc = base + nb * per - 1;
        for (int j = 0; j < nb; j++) begin
            sb_q.push_back('{base + j * per, 1'b1, req});
            sb_q.push_back('{base + j * per + per / 2, 1'b0, req});
        end
        while (cyc < endc) begin
            @(negedge clk);
            if (cyc == base) check(in_frame == 1'b1, "R4", int'(in_frame), 1);
            if (wiggle && cyc > base + per && cyc < endc - 2)
                rx = ((cyc / 5) % 2 == 0) ? 1'b1 : 1'b0;
        end
        check(in_frame == 1'b1, "R8", int'(in_frame), 1);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        rx = 1'b1;
        check(in_frame == 1'b0, "R8", int'(in_frame), 0);
        check(sb_q.size() == 0, "R5 R6", sb_q.size(), 0);
    endtask

    initial begin
        wait_cyc(5);
        check(in_frame == 1'b0, "R10", int'(in_frame), 0);
        check(boundary_stb == 1'b0 && sample_stb == 1'b0, "R10", int'(boundary_stb | sample_stb), 0);
        rst = 1'b0;
        @(negedge clk);
        check(in_frame == 1'b0, "R10", int'(in_frame), 0);
        check(cfg_err == 1'b0, "R2", int'(cfg_err), 0);

        // Early edge before eleven recessive bits: ignored
        cur_req = "R3";
        wait_cyc(3 * PS);
        rx = 1'b0;
        wait_cyc(PS);
        rx = 1'b1;
        wait_cyc(2 * PS);
        check(in_frame == 1'b0, "R3", int'(in_frame), 0);
        wait_cyc(12 * PS);

        // Slow rate frame
        cur_req = "R5";
        run_frame(PS, 4, "R1 R5 R6 slow", 1'b0);

        // Edge too soon after frame-done: ignored
        cur_req = "R8";
        rate_sel = 3'b010;
        wait_cyc(3 * PM);
        rx = 1'b0;
        wait_cyc(PM);
        rx = 1'b1;
        wait_cyc(PM);
        check(in_frame == 1'b0, "R8", int'(in_frame), 0);
        wait_cyc(12 * PM);

        // Medium rate frame with line activity inside it
        cur_req = "R7";
        run_frame(PM, 5, "R1 R7 medium", 1'b1);

        // Fast rate frame
        cur_req = "R5";
        rate_sel = 3'b100;
        wait_cyc(12 * PF);
        run_frame(PF, 6, "R1 R5 R6 fast", 1'b0);

        // Configuration faults
        cur_req = "R2";
        @(negedge clk); rate_sel = 3'b000; #1;
        check(cfg_err == 1'b1, "R2", int'(cfg_err), 1);
        @(negedge clk); rate_sel = 3'b111; #1;
        check(cfg_err == 1'b1, "R2", int'(cfg_err), 1);
        @(negedge clk); rate_sel = 3'b011; #1;
        check(cfg_err == 1'b1, "R2", int'(cfg_err), 1);
        check(in_frame == 1'b0, "R2", int'(in_frame), 0);
        @(negedge clk); rate_sel = 3'b100; #1;
        check(cfg_err == 1'b0, "R2", int'(cfg_err), 0);
        wait_cyc(12 * PF);

        // Fault in the very cycle the start-of-frame edge is detected
        cur_req = "R9";
        begin
            int n0;
            @(negedge clk);
            rx = 1'b0;
            n0 = cyc;
            while (cyc < n0 + 2) @(negedge clk);
            rate_sel = 3'b110;
            #1;
            check(cfg_err == 1'b1, "R9", int'(cfg_err), 1);
            @(negedge clk);
            rate_sel = 3'b100;
            check(in_frame == 1'b0, "R9", int'(in_frame), 0);
            wait_cyc(3 * PF);
            check(in_frame == 1'b0, "R9", int'(in_frame), 0);
            rx = 1'b1;
        end
        wait_cyc(12 * PF);
        run_frame(PF, 3, "R9 recovery", 1'b0);

        // Back to slow rate
        cur_req = "R1";
        rate_sel = 3'b001;
        wait_cyc(12 * PS);
        run_frame(PS, 2, "R1 slow again", 1'b0);
        wait_cyc(2 * PS);

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(100000 * 4);
        if (!done_flag) begin
            done_flag = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired at cycle %0d: actual=running expected=finished", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule